// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Shift Engine

This block sends and receives short bit strings to a serial EEPROM over three wires: a serial clock, a bidirectional data line, and a chip select. The chip select is not part of the block; software raises it on a general-purpose output before a transaction and lowers it afterwards. A CPU controls the engine through two registers. One is a write-only control word that starts a single command of zero to eight serial clock pulses. The other is an 8-bit data register. It supplies the bits that are shifted out and collects the bits that are shifted in.

A command either shifts data out on the data line, most significant bit first, or samples the line and packs the received bits into the low end of the data register. A release flag in the control word frees the data line after a write. A zero-count command produces no clocks and only sets how the data line is driven. Software uses it to take back the line after a read. A busy flag covers the whole command, and a one-cycle completion pulse follows its end. Each serial bit period is set by a divider parameter.

Top module: `eep3w_engine`

## Requirements
- R1: A command starts only when `ctl_we` is high while the engine is idle. `busy` goes high in the cycle after that write.
- R2: Control word layout: bit 5 is the release flag, bit 4 selects read (1) or write (0), and bits 3:0 hold the bit count. A count above 8 is treated as 8.
- R3: `sclk` idles low and gives exactly the effective count of pulses. Each pulse is low for HALF_CYC system cycles and then high for HALF_CYC cycles, so rising edges are 2*HALF_CYC cycles apart.
- R4: On a write, `sdo` carries bit 7 of the data register and is stable at every `sclk` rising edge. The register shifts left with zero fill on each falling edge. After n bits, `dat_rdata` equals the old value shifted left by n.
- R5: On a read, `sdi` is sampled at each `sclk` rising edge and shifted into bit 0. After n bits, the low n bits hold the received bits in arrival order (first bit highest), and the upper bits hold the old value shifted left by n.
- R6: With an effective count of 0, no `sclk` pulse occurs and `sdo_oe` becomes the inverse of the release flag, for either direction.
- R7: During a write, `sdo_oe` is 1 for every shift cycle. After the last bit it falls to 0 if the release flag is set, and it stays 1 otherwise.
- R8: During a read with a nonzero count, `sdo_oe` is 0 for the whole command and afterwards.
- R9: `busy` stays high for exactly n*2*HALF_CYC+1 cycles, where n is the effective count.
- R10: `done_irq` is high for exactly one cycle: the first cycle in which `busy` is low again. This includes zero-count commands.
- R11: A `ctl_we` that arrives while `busy` is high is ignored.
- R12: `dat_rdata` always shows the data register. `dat_we` loads it only while idle and is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 6 | Control word: release, read, 4-bit count |
| dat_we | input | 1 | Data register write strobe |
| dat_wdata | input | W | Data register write value |
| dat_rdata | output | W | Data register contents |
| busy | output | 1 | Command in progress |
| done_irq | output | 1 | One-cycle completion pulse |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Data line drive enable (0 = high impedance) |
| sdi | input | 1 | Serial data in |

## Verification
The bench targets the count boundaries 0, 1, 8 and an over-range 15. A design that does not clamp would run 15 pulses or wrap the count, and one that mishandles zero would emit a stray clock or leave the line drive wrong. Reads of partial length check right-justification against the old contents. A design that loads the received bits from the top would place them in the wrong positions. Writes with and without the release flag check the drive state after the last bit. Control and data writes injected mid-command check that a busy engine neither restarts nor lets its shift register be overwritten, which would show up as a changed pulse count or corrupted serial data.

// File: rtl/eep3w_pkg.sv
package eep3w_pkg;
  localparam int unsigned CTL_W   = 6;
  localparam int unsigned CNT_W   = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2,
    ST_DONE = 2'd3
  } seq_state_e;

  // bit 5 release, bit 4 read, bits 3:0 count
  typedef struct packed {
    logic             rel;
    logic             rd;
    logic [CNT_W-1:0] cnt;
  } cmd_t;
endpackage

// File: rtl/eep3w_rst_sync.sv
module eep3w_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/eep3w_halftimer.sv
module eep3w_halftimer #(
  parameter int unsigned HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign tick = run && (cnt_q == LAST);

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!run || tick) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R3: half-period counter never leaves its range
  assert_half_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/eep3w_shreg.sv
module eep3w_shreg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         shl_out,
  input  logic         shl_in,
  input  logic         sdi,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;
  logic         q_en;

  always_comb begin
    q_en = load | shl_out | shl_in;
    q_d  = q;
    if (load)         q_d = load_data;
    else if (shl_out) q_d = {q[W-2:0], 1'b0};
    else if (shl_in)  q_d = {q[W-2:0], sdi};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_d;
  end

  // R12: a software load never coincides with a shift
  assert_single_update_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load, shl_out, shl_in}));
endmodule

// File: rtl/eep3w_seq.sv
module eep3w_seq
  import eep3w_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  cmd_t cmd,
  input  logic tick,
  output logic run,
  output logic shl_out,
  output logic shl_in,
  output logic busy,
  output logic irq,
  output logic sclk,
  output logic oe
);
  localparam int unsigned RW = $clog2(W + 1);
  localparam logic [RW-1:0] RMAX = RW'(W);

  seq_state_e    st_q, st_d;
  logic [RW-1:0] rem_q, rem_d, clamped;
  logic          rd_q, rd_d, rel_q, rel_d;
  logic          oe_d, irq_d, sclk_d;
  logic          ctx_en;

  assign clamped = (int'(cmd.cnt) > int'(W)) ? RMAX : RW'(cmd.cnt);
  assign run     = (st_q == ST_LOW) || (st_q == ST_HIGH);
  assign busy    = (st_q != ST_IDLE);

  always_comb begin
    st_d    = st_q;
    rem_d   = rem_q;
    rd_d    = rd_q;
    rel_d   = rel_q;
    oe_d    = oe;
    irq_d   = 1'b0;
    shl_out = 1'b0;
    shl_in  = 1'b0;
    ctx_en  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          ctx_en = 1'b1;
          rd_d   = cmd.rd;
          rel_d  = cmd.rel;
          rem_d  = clamped;
          if (clamped == '0) begin
            oe_d = ~cmd.rel;
            st_d = ST_DONE;
          end else begin
            oe_d = ~cmd.rd;
            st_d = ST_LOW;
          end
        end
      end
      ST_LOW: begin
        if (tick) begin
          st_d   = ST_HIGH;
          shl_in = rd_q;
        end
      end
      ST_HIGH: begin
        if (tick) begin
          ctx_en  = 1'b1;
          rem_d   = rem_q - RW'(1);
          shl_out = ~rd_q;
          if (rem_q == RW'(1)) begin
            st_d = ST_DONE;
            if (!rd_q && rel_q) oe_d = 1'b0;
          end else begin
            st_d = ST_LOW;
          end
        end
      end
      ST_DONE: begin
        st_d  = ST_IDLE;
        irq_d = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
    sclk_d = (st_d == ST_HIGH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      irq  <= 1'b0;
      sclk <= 1'b0;
      oe   <= 1'b0;
    end else begin
      st_q <= st_d;
      irq  <= irq_d;
      sclk <= sclk_d;
      oe   <= oe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      rd_q  <= 1'b0;
      rel_q <= 1'b0;
    end else if (ctx_en) begin
      rem_q <= rem_d;
      rd_q  <= rd_d;
      rel_q <= rel_d;
    end
  end

  // R10: completion pulse lasts one cycle
  assert_irq_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R10: pulse coincides with the first idle cycle
  assert_irq_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq);
  // R3: serial clock low whenever no bit is being shifted
  assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !sclk);
  // R8: data line released through a read
  assert_read_hiz_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && rd_q) |-> !oe);
  // R7: data line driven through a write
  assert_write_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !rd_q) |-> oe);
  // R2: remaining count never exceeds the clamp
  assert_rem_clamp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rem_q <= RMAX);
  // R11: a running command is never reloaded
  assert_no_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (rem_q <= $past(rem_q)));
endmodule

// File: rtl/eep3w_engine.sv
module eep3w_engine
  import eep3w_pkg::*;
#(
  parameter int unsigned W        = 8,
  parameter int unsigned HALF_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             dat_we,
  input  logic [W-1:0]     dat_wdata,
  output logic [W-1:0]     dat_rdata,
  output logic             busy,
  output logic             done_irq,
  output logic             sclk,
  output logic             sdo,
  output logic             sdo_oe,
  input  logic             sdi
);
  logic rst_ni;
  logic start, load, tick, run, shl_out, shl_in;
  cmd_t cmd;

  assign cmd   = cmd_t'(ctl_wdata);
  assign start = ctl_we & ~busy;
  assign load  = dat_we & ~busy;
  assign sdo   = dat_rdata[W-1];

  eep3w_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ni)
  );

  eep3w_halftimer #(.HALF_CYC(HALF_CYC)) u_tmr (
    .clk   (clk),
    .rst_n (rst_ni),
    .run   (run),
    .tick  (tick)
  );

  eep3w_seq #(.W(W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_ni),
    .start   (start),
    .cmd     (cmd),
    .tick    (tick),
    .run     (run),
    .shl_out (shl_out),
    .shl_in  (shl_in),
    .busy    (busy),
    .irq     (done_irq),
    .sclk    (sclk),
    .oe      (sdo_oe)
  );

  eep3w_shreg #(.W(W)) u_sr (
    .clk       (clk),
    .rst_n     (rst_ni),
    .load      (load),
    .load_data (dat_wdata),
    .shl_out   (shl_out),
    .shl_in    (shl_in),
    .sdi       (sdi),
    .q         (dat_rdata)
  );

  // R11: a control write during a command keeps it running
  assert_ctl_ignored_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy && ctl_we && !done_irq && $past(busy)) |=> (busy || done_irq));
  // R1: idle control write always makes the engine busy
  assert_start_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctl_we && !busy) |=> busy);
  // R12: data register holds while the serial clock is high
  assert_hold_high_R12: assert property (@(posedge clk) disable iff (!rst_ni)
    (sclk && $past(sclk) && busy && $past(busy)) |-> $stable(dat_rdata));
endmodule

// File: tb/sim_eep3w_engine.sv
`timescale 1ns/1ps
module sim_eep3w_engine;
  localparam int W = 8;
  localparam int HALF = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_we = 1'b0, dat_we = 1'b0, sdi = 1'b0;
  logic [5:0] ctl_wdata = '0;
  logic [W-1:0] dat_wdata = '0;
  logic [W-1:0] dat_rdata;
  logic busy, done_irq, sclk, sdo, sdo_oe;

  int checks = 0, failures = 0;
  bit exp_q[$];
  bit wr_mode = 0, rd_active = 0;
  int pulses = 0, rd_pos = 0;
  logic [7:0] rd_byte = '0;
  realtime last_rise = -1.0;

  always #5 clk = ~clk;

  eep3w_engine #(.W(W), .HALF_CYC(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .dat_we(dat_we), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
    .busy(busy), .done_irq(done_irq), .sclk(sclk), .sdo(sdo),
    .sdo_oe(sdo_oe), .sdi(sdi)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops expected write bits at every serial rising edge
  always @(posedge sclk) begin
    pulses++;
    if (last_rise >= 0.0)
      chk(($realtime - last_rise) == 2*HALF*10.0, "R3 sclk period",
          int'($realtime - last_rise), 2*HALF*10);
    last_rise = $realtime;
    if (wr_mode) begin
      if (exp_q.size() == 0) chk(0, "R4 unexpected bit", 1, 0);
      else begin
        bit e;
        e = exp_q.pop_front();
        chk(sdo == e, "R4 sdo bit", int'(sdo), int'(e));
      end
    end
  end

  // EEPROM model: next read bit after every serial falling edge
  always @(negedge sclk) begin
    if (rd_active) begin
      rd_pos++;
      if (rd_pos < 8) sdi = rd_byte[7-rd_pos];
    end
  end

  task automatic set_dat(input logic [7:0] v);
    @(negedge clk); dat_we = 1; dat_wdata = v;
    @(negedge clk); dat_we = 0;
  endtask

  task automatic run_cmd(input bit rd, input bit rel, input int cnt,
                         input logic [7:0] rbyte, input bit poke);
    int n, cyc;
    logic [7:0] pre;
    logic [15:0] wide;
    logic [7:0] exp_d;
    bit exp_oe;
    n = (cnt > 8) ? 8 : cnt;
    pre = dat_rdata;
    pulses = 0;
    last_rise = -1.0;
    wr_mode = !rd;
    if (!rd) for (int i = 0; i < n; i++) exp_q.push_back(pre[7-i]);
    if (rd) begin rd_byte = rbyte; rd_pos = 0; sdi = rbyte[7]; rd_active = 1; end
    @(negedge clk);
    ctl_we = 1; ctl_wdata = {rel, rd, 4'(cnt)};
    @(negedge clk);
    ctl_we = 0;
    chk(busy == 1, "R1 busy after write", int'(busy), 1);
    cyc = 0;
    while (busy && cyc < 200) begin
      cyc++;
      if (n > 0 && cyc < n*2*HALF) begin
        if (rd) chk(sdo_oe == 0, "R8 oe during read", int'(sdo_oe), 0);
        else    chk(sdo_oe == 1, "R7 oe during write", int'(sdo_oe), 1);
      end
      if (poke && cyc == 3) begin
        ctl_we = 1; ctl_wdata = 6'b000001;
        dat_we = 1; dat_wdata = 8'h00;
      end else begin
        ctl_we = 0; dat_we = 0;
      end
      @(negedge clk);
    end
    ctl_we = 0; dat_we = 0;
    chk(cyc == n*2*HALF + 1, "R9 busy length", cyc, n*2*HALF + 1);
    chk(done_irq == 1, "R10 irq at end", int'(done_irq), 1);
    chk(pulses == n, (n == 0) ? "R6 no clocks" : "R3 pulse count", pulses, n);
    if (rd) begin
      wide = ({8'h00, pre} << n) | ({8'h00, rbyte} >> (8 - n));
      exp_d = wide[7:0];
      chk(dat_rdata == exp_d, "R5 read data", int'(dat_rdata), int'(exp_d));
    end else begin
      wide = {8'h00, pre} << n;
      exp_d = wide[7:0];
      chk(dat_rdata == exp_d, "R4 shifted data", int'(dat_rdata), int'(exp_d));
      chk(exp_q.size() == 0, "R4 bits left", exp_q.size(), 0);
    end
    if (poke) chk(cyc == n*2*HALF + 1, "R11 poke ignored", cyc, n*2*HALF + 1);
    if (n == 0) exp_oe = !rel;
    else if (rd) exp_oe = 0;
    else exp_oe = !rel;
    chk(sdo_oe == exp_oe, (n == 0) ? "R6 oe state" : (rd ? "R8 oe after" : "R7 oe after"),
        int'(sdo_oe), int'(exp_oe));
    @(negedge clk);
    chk(done_irq == 0, "R10 irq single", int'(done_irq), 0);
    chk(sclk == 0, "R3 sclk idle", int'(sclk), 0);
    rd_active = 0; wr_mode = 0; exp_q.delete();
  endtask

  initial begin
    fork
      begin
        #1500000;
        failures++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(busy == 0, "R1 reset busy", int'(busy), 0);
    chk(done_irq == 0, "R10 reset irq", int'(done_irq), 0);
    chk(sclk == 0, "R3 reset sclk", int'(sclk), 0);
    chk(sdo_oe == 0, "R6 reset oe", int'(sdo_oe), 0);
    chk(dat_rdata == 0, "R12 reset data", int'(dat_rdata), 0);

    set_dat(8'hA5);
    chk(dat_rdata == 8'hA5, "R12 data load", int'(dat_rdata), 8'hA5);
    run_cmd(0, 0, 8, 8'h00, 0);          // full write, keep driving
    set_dat(8'hC3);
    run_cmd(0, 1, 6, 8'h00, 0);          // partial write with release
    set_dat(8'h5A);
    run_cmd(0, 0, 1, 8'h00, 0);          // single bit
    run_cmd(0, 1, 0, 8'h00, 0);          // zero count releases line (R6)
    run_cmd(1, 0, 0, 8'h00, 0);          // zero count read direction drives line (R6)
    set_dat(8'hFF);
    run_cmd(1, 0, 5, 8'h96, 0);          // partial read right-justified (R5)
    set_dat(8'h00);
    run_cmd(1, 0, 8, 8'h3C, 0);          // full read (R8)
    run_cmd(0, 0, 0, 8'h00, 0);          // retake the line after read (R6)
    set_dat(8'h81);
    run_cmd(0, 0, 15, 8'h00, 0);         // over-range count clamps (R2)
    set_dat(8'hE7);
    run_cmd(0, 0, 8, 8'h00, 1);          // writes while busy ignored (R11, R12)
    set_dat(8'h12);
    run_cmd(1, 1, 4, 8'hB0, 1);          // read with pokes (R11, R12)

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule